// File: doc/BRIEF.md
# Digital Input Port with Per-Line Edge Capture

The block presents sixteen external digital lines to a host as a polled input port. Every line passes through a synchroniser, and the synchronised word can be read at any time. No sampling clock or capture strobe is involved.

The eight least significant lines also feed an edge-capture stage. A configuration word enables rising-edge and falling-edge detection independently on each of these eight lines. A line whose enabled edge is seen sets its own sticky capture bit. The first such capture raises a single-cycle interrupt pulse. The host reads the capture bits and clears any subset of them with a mask strobe. A clear re-arms the interrupt, and it also reopens detection on the cleared lines. A capture bit that is already set ignores further edges on its line until it is cleared. An edge that coincides with the clear of its own line is not lost.

Top module: `dig_edge_capture`

## Requirements
- R1: `port_value` equals the value `pin_in` had two clock edges earlier on all 16 lines (two-stage synchroniser); it is readable at any time and nothing else changes it.
- R2: Lines 8 to 15 never set a capture bit and never raise `irq`, whatever their transitions and whatever the configuration.
- R3: A write with `cfg_we` loads `cfg_wdata`: bit i (0..7) enables rising-edge capture on line i, and bit 8+i enables falling-edge capture on line i. Each line can therefore be set to off, rising only, falling only or both, and `cfg_value` returns the stored word.
- R4: A transition of an enabled polarity on line i sets `latch_value[i]` at the third rising clock edge after the pin changes. The bit then stays set until a clear covers it. A transition of a disabled polarity leaves it at 0.
- R5: When a capture occurs while the interrupt is armed, `irq` is high for exactly the one cycle in which the new capture bit first appears.
- R6: After `irq` has fired, it stays low until the next clear strobe. Further edges on a line whose capture bit is already set are ignored. Edges on other enabled lines still set their capture bits.
- R7: A cycle with `clr_we` high clears every capture bit selected in `clr_mask` and re-arms the interrupt. A cleared line detects its next enabled edge and raises `irq` again.
- R8: An enabled edge on line i in the same cycle as a clear that selects bit i leaves `latch_value[i]` set and raises `irq`.
- R9: Reset (`rst_n` low) clears the capture bits, the configuration word and `irq`, and arms the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 16 | Asynchronous external digital lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word: [7:0] rising enables, [15:8] falling enables |
| clr_we | input | 1 | Capture clear strobe |
| clr_mask | input | 8 | Capture bits to clear when `clr_we` is high |
| port_value | output | 16 | Synchronised state of all lines |
| cfg_value | output | 16 | Stored configuration word |
| latch_value | output | 8 | Sticky capture bits, one per low line |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The main sweep covers every low line and each of the four polarity settings, and drives both a rising and a falling transition through every combination. This separates a line-index error from a swapped or missing polarity enable, and it confirms that the interrupt pulse accompanies exactly the enabled cases. Bit patterns on all sixteen lines check the two-cycle synchroniser delay, and transitions on the upper byte show that those lines cannot capture. A scripted sequence of repeated edges, partial clears and a clear that lands in the same cycle as an edge separates interrupt suppression, re-arming and the no-loss rule from one another.

// File: rtl/dec_pkg.sv
package dec_pkg;

    typedef enum logic [1:0] {
        POL_OFF  = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } pol_mode_e;

    function automatic logic pol_hit(input pol_mode_e mode,
                                     input logic rise_ev,
                                     input logic fall_ev);
        logic h;
        unique case (mode)
            POL_RISE: h = rise_ev;
            POL_FALL: h = fall_ev;
            POL_BOTH: h = rise_ev | fall_ev;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/dec_sync.sv
module dec_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];

    // R1: each stage carries the previous stage's value one cycle later
    assert_sync_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.chain[STAGES-1] == $past(st_q.chain[STAGES-2])));

endmodule

// File: rtl/dec_edge_detect.sv
module dec_edge_detect #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level_in,
    output logic [LINES-1:0] rise_ev,
    output logic [LINES-1:0] fall_ev
);
    typedef struct packed {
        logic [LINES-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_comb begin
            rise_ev[i] = level_in[i] & ~st_q.prev[i];
            fall_ev[i] = ~level_in[i] & st_q.prev[i];
        end
    end

endmodule

// File: rtl/dec_latch_ctrl.sv
module dec_latch_ctrl
    import dec_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   rise_ev,
    input  logic [LINES-1:0]   fall_ev,
    input  logic               cfg_we,
    input  logic [2*LINES-1:0] cfg_wdata,
    input  logic               clr_we,
    input  logic [LINES-1:0]   clr_mask,
    output logic [2*LINES-1:0] cfg_value,
    output logic [LINES-1:0]   latch_value,
    output logic               irq
);
    typedef struct packed {
        logic [LINES-1:0] en_rise;
        logic [LINES-1:0] en_fall;
        logic [LINES-1:0] captured;
        logic             armed;
        logic             irq;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [LINES-1:0] raw_hit;
    logic [LINES-1:0] clr_eff;
    logic [LINES-1:0] new_hit;
    logic             fire;

    for (genvar i = 0; i < LINES; i++) begin : g_hit
        pol_mode_e mode_i;
        always_comb begin
            mode_i     = pol_mode_e'({st_q.en_fall[i], st_q.en_rise[i]});
            raw_hit[i] = pol_hit(mode_i, rise_ev[i], fall_ev[i]);
        end
    end

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_we ? clr_mask : '0;
        new_hit = raw_hit & (~st_q.captured | clr_eff);
        fire    = (|new_hit) & (st_q.armed | clr_we);

        st_d.captured = (st_q.captured & ~clr_eff) | new_hit;

        if (fire) begin
            st_d.armed = 1'b0;
        end else if (clr_we) begin
            st_d.armed = 1'b1;
        end

        st_d.irq = fire;

        if (cfg_we) begin
            st_d.en_rise = cfg_wdata[LINES-1:0];
            st_d.en_fall = cfg_wdata[2*LINES-1:LINES];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_value   = {st_q.en_fall, st_q.en_rise};
    assign latch_value = st_q.captured;
    assign irq         = st_q.irq;

    // R4: a set capture bit survives unless its clear was strobed
    assert_capture_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.captured) & ~$past(clr_eff)) & ~st_q.captured) == '0));

    // R3: a newly set capture bit needs one of its polarities enabled
    assert_capture_needs_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.captured & ~$past(st_q.captured))
                   & ~($past(st_q.en_rise) | $past(st_q.en_fall))) == '0));

    // R5: the interrupt pulse always comes with a set capture bit
    assert_irq_has_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (|st_q.captured));

    // R6: without a clear strobe the pulse cannot repeat in the next cycle
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr_we) |=> !st_q.irq);

endmodule

// File: rtl/dig_edge_capture.sv
module dig_edge_capture #(
    parameter int WIDTH       = 16,
    parameter int EDGE_LINES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WIDTH-1:0]        pin_in,
    input  logic                    cfg_we,
    input  logic [2*EDGE_LINES-1:0] cfg_wdata,
    input  logic                    clr_we,
    input  logic [EDGE_LINES-1:0]   clr_mask,
    output logic [WIDTH-1:0]        port_value,
    output logic [2*EDGE_LINES-1:0] cfg_value,
    output logic [EDGE_LINES-1:0]   latch_value,
    output logic                    irq
);
    logic [WIDTH-1:0]      sync_word;
    logic [EDGE_LINES-1:0] rise_ev;
    logic [EDGE_LINES-1:0] fall_ev;

    dec_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_word)
    );

    dec_edge_detect #(.LINES(EDGE_LINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sync_word[EDGE_LINES-1:0]),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    dec_latch_ctrl #(.LINES(EDGE_LINES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_ev     (rise_ev),
        .fall_ev     (fall_ev),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .clr_we      (clr_we),
        .clr_mask    (clr_mask),
        .cfg_value   (cfg_value),
        .latch_value (latch_value),
        .irq         (irq)
    );

    assign port_value = sync_word;

endmodule

// File: tb/dig_edge_capture_test.sv
module dig_edge_capture_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        clr_we = 1'b0;
    logic [7:0]  clr_mask = '0;
    logic [15:0] port_value;
    logic [15:0] cfg_value;
    logic [7:0]  latch_value;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dig_edge_capture uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .clr_we      (clr_we),
        .clr_mask    (clr_mask),
        .port_value  (port_value),
        .cfg_value   (cfg_value),
        .latch_value (latch_value),
        .irq         (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_clear(input logic [7:0] m);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_latch;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 latch at reset", {8'h0, latch_value}, 16'h0);
        check("R9 cfg at reset", cfg_value, 16'h0);
        check("R9 irq at reset", {15'h0, irq}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: synchroniser delay on full-width patterns, no capture enabled
        foreach (pattern_list[p]) begin
            logic [15:0] prev_v;
            prev_v = pin_in;
            @(negedge clk);
            pin_in = pattern_list[p];
            @(negedge clk);
            check("R1 one edge after change", port_value, prev_v);
            @(negedge clk);
            check("R1 two edges after change", port_value, pattern_list[p]);
        end
        check("R3 no capture while all disabled", {8'h0, latch_value}, 16'h0);
        @(negedge clk);
        pin_in = '0;
        wait3();

        // R3 / R4 / R5: sweep every line, every polarity mode, both transitions
        for (int line = 0; line < 8; line++) begin
            for (int mode = 0; mode < 4; mode++) begin
                logic re, fe;
                re = mode[0];
                fe = mode[1];
                write_cfg({8'(fe) << line, 8'(re) << line});
                check("R3 cfg readback", cfg_value, {8'(fe) << line, 8'(re) << line});
                do_clear(8'hFF);
                pin_in[line] = 1'b1;
                wait3();
                exp_latch = re ? (8'h1 << line) : 8'h0;
                check("R4 rising capture", {8'h0, latch_value}, {8'h0, exp_latch});
                check("R5 rising irq", {15'h0, irq}, {15'h0, re});
                @(negedge clk);
                check("R5 irq one cycle", {15'h0, irq}, 16'h0);
                check("R4 capture holds", {8'h0, latch_value}, {8'h0, exp_latch});
                do_clear(8'hFF);
                pin_in[line] = 1'b0;
                wait3();
                exp_latch = fe ? (8'h1 << line) : 8'h0;
                check("R4 falling capture", {8'h0, latch_value}, {8'h0, exp_latch});
                check("R5 falling irq", {15'h0, irq}, {15'h0, fe});
                do_clear(8'hFF);
            end
        end

        // R2: upper lines never capture
        write_cfg(16'hFFFF);
        do_clear(8'hFF);
        for (int u = 8; u < 16; u++) begin
            pin_in[u] = 1'b1;
            @(negedge clk);
            check("R2 no irq from upper line", {15'h0, irq}, 16'h0);
            @(negedge clk);
            check("R2 no irq from upper line", {15'h0, irq}, 16'h0);
            @(negedge clk);
            check("R2 no irq from upper line", {15'h0, irq}, 16'h0);
            check("R2 no capture from upper line", {8'h0, latch_value}, 16'h0);
            pin_in[u] = 1'b0;
            wait3();
            check("R2 no capture on upper fall", {8'h0, latch_value}, 16'h0);
            check("R2 no irq on upper fall", {15'h0, irq}, 16'h0);
        end
        check("R1 upper lines readable", port_value, 16'h0000);

        // R6: suppression after first fire
        pin_in[0] = 1'b1;
        wait3();
        check("R5 first capture", {8'h0, latch_value}, 16'h0001);
        check("R5 first irq", {15'h0, irq}, 16'h1);
        pin_in[0] = 1'b0;
        wait3();
        check("R6 latched line ignores edge", {8'h0, latch_value}, 16'h0001);
        check("R6 no irq repeat", {15'h0, irq}, 16'h0);
        pin_in[1] = 1'b1;
        wait3();
        check("R6 other line still captures", {8'h0, latch_value}, 16'h0003);
        check("R6 irq suppressed for other line", {15'h0, irq}, 16'h0);

        // R7: partial clear and re-arm
        do_clear(8'h01);
        check("R7 partial clear", {8'h0, latch_value}, 16'h0002);
        pin_in[0] = 1'b1;
        wait3();
        check("R7 cleared line captures again", {8'h0, latch_value}, 16'h0003);
        check("R7 irq re-armed", {15'h0, irq}, 16'h1);
        @(negedge clk);
        check("R7 irq drops", {15'h0, irq}, 16'h0);

        // R8: edge in the same cycle as its own clear
        pin_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        clr_we = 1'b1; clr_mask = 8'h01;
        @(negedge clk);
        clr_we = 1'b0; clr_mask = '0;
        check("R8 coincident edge kept", {8'h0, latch_value}, 16'h0003);
        check("R8 coincident edge irq", {15'h0, irq}, 16'h1);

        // R9: reset clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 latch after reset", {8'h0, latch_value}, 16'h0);
        check("R9 cfg after reset", cfg_value, 16'h0);
        check("R9 irq after reset", {15'h0, irq}, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    logic [15:0] pattern_list [5] = '{16'hA5C3, 16'hFFFF, 16'h0000, 16'h8001, 16'h5A3C};

endmodule